// File: doc/BRIEF.md
# ALU Operation Step Sequencer

This controller turns one decoded ALU instruction into the series of bus-enable and register-set strobes needed to run it over a single shared data bus. A one-cycle `start` pulse presents the instruction. Its fields are an opcode, a flag that says whether the operation takes one or two operands, and a source choice for each operand. Each source choice is either a 2-bit index into a small bank of general registers or a separate select that puts the accumulator on the bus. The controller captures these fields when it accepts the start. From the next cycle on, it walks one step per clock.

A unary operation takes three steps. Step one enables the source. Step two keeps the source enabled and presents the opcode. Step three keeps both and strobes the accumulator load. A binary operation takes five steps. Step one enables the first source. Step two keeps it enabled and strobes the temporary operand register. Step three enables the second source. Step four keeps it enabled and presents the opcode. Step five keeps both and strobes the accumulator load. A `done` pulse then marks completion. Because the accumulator can be chosen as a bus source, the result of one instruction can feed the next one.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_A_EN`, `ST_A_TMP`, `ST_B_EN`, `ST_B_OP`, `ST_B_ACC`, `ST_U_OP`, `ST_U_ACC` and `ST_DONE`. The transitions are:
- `ST_IDLE`→`ST_A_EN` on an accepted start.
- `ST_A_EN`→`ST_U_OP` when the instruction is unary, or `ST_A_EN`→`ST_A_TMP` when it is binary.
- Unary path: `ST_U_OP`→`ST_U_ACC`→`ST_DONE`.
- Binary path: `ST_A_TMP`→`ST_B_EN`→`ST_B_OP`→`ST_B_ACC`→`ST_DONE`.
- `ST_DONE`→`ST_IDLE`.

Top module: `alu_step_seq`

## Requirements
- R1: While in reset and while idle, every bus enable and `acc_oe` are low, `tmp_set`, `acc_set`, `busy` and `done` are low, and `alu_op` equals `NOP_CODE` (default 0).
- R2: For a unary instruction (`instr_binary`=0), three step cycles follow. Step 1 enables source A. Step 2 enables source A and drives `alu_op` with the opcode. Step 3 enables source A, drives the opcode and raises `acc_set`.
- R3: For a binary instruction (`instr_binary`=1), five step cycles follow. Step 1 enables A. Step 2 enables A with `tmp_set`. Step 3 enables B. Step 4 enables B with the opcode. Step 5 enables B with the opcode and `acc_set`. `alu_op` holds `NOP_CODE` in steps without the opcode.
- R4: In every cycle, at most one of the `reg_en` bits and `acc_oe` is high.
- R5: When an operand's ACC select is 0, its index k enables only `reg_en` bit k (value 1<<k). When the ACC select is 1, `acc_oe` is high, `reg_en` is 0 and the index is ignored.
- R6: `done` is high for exactly one cycle, the cycle right after the `acc_set` step, with no enables and `alu_op`=`NOP_CODE`. The cycle after that is idle.
- R7: A start pulse while `busy` is high has no effect, including a start in the `done` cycle. Instruction inputs that change after acceptance do not alter the running sequence.
- R8: Step 1 appears in the cycle after the clock edge that samples `start` while idle. A start given in the first idle cycle after `done` is accepted, so instructions can be chained, including ones that read the accumulator.
- R9: `busy` is high from step 1 through the `done` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to run the presented instruction |
| instr_opcode | input | OPW | ALU opcode of the instruction |
| instr_binary | input | 1 | 1 = two operands, 0 = one operand |
| instr_a_idx | input | IDXW | Register index of the first operand |
| instr_a_acc | input | 1 | First operand comes from the accumulator |
| instr_b_idx | input | IDXW | Register index of the second operand |
| instr_b_acc | input | 1 | Second operand comes from the accumulator |
| reg_en | output | NREG | One-hot bus enable of the register bank |
| acc_oe | output | 1 | Accumulator drives the bus |
| tmp_set | output | 1 | Load strobe of the temporary operand register |
| acc_set | output | 1 | Load strobe of the accumulator |
| alu_op | output | OPW | Opcode presented to the ALU, `NOP_CODE` when none |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two things can land in the same cycle here. One is a fresh `start` arriving in a step or `done` cycle, which must be dropped. The other is the accumulator both driving the bus and being loaded, which happens in the last step of an instruction that reads ACC. The bench provokes both on purpose. It raises `start` with scrambled instruction fields during random steps and during the `done` cycle. It also issues back-to-back instructions whose sources select the accumulator. Every cycle is compared against a step table computed in the bench. An ignored start must leave the sequence unchanged and must be followed by an idle cycle. A load of a bus-driving accumulator must still show exactly one driver.

// File: rtl/alu_seq_pkg.sv
package alu_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_A_EN  = 4'd1,
        ST_A_TMP = 4'd2,
        ST_B_EN  = 4'd3,
        ST_B_OP  = 4'd4,
        ST_B_ACC = 4'd5,
        ST_U_OP  = 4'd6,
        ST_U_ACC = 4'd7,
        ST_DONE  = 4'd8
    } seq_state_e;

    typedef enum logic [1:0] {
        PICK_NONE = 2'd0,
        PICK_A    = 2'd1,
        PICK_B    = 2'd2
    } src_pick_e;

    typedef struct packed {
        src_pick_e pick;
        logic      op_on;
        logic      tmp_set;
        logic      acc_set;
        logic      done;
        logic      busy;
    } seq_ctrl_t;

endpackage

// File: rtl/alu_seq_latch.sv
module alu_seq_latch #(
    parameter int OPW  = 4,
    parameter int IDXW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [OPW-1:0]  opcode_i,
    input  logic            binary_i,
    input  logic [IDXW-1:0] a_idx_i,
    input  logic            a_acc_i,
    input  logic [IDXW-1:0] b_idx_i,
    input  logic            b_acc_i,
    output logic [OPW-1:0]  opcode_q,
    output logic            binary_q,
    output logic [IDXW-1:0] a_idx_q,
    output logic            a_acc_q,
    output logic [IDXW-1:0] b_idx_q,
    output logic            b_acc_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opcode_q <= '0;
            binary_q <= 1'b0;
            a_idx_q  <= '0;
            a_acc_q  <= 1'b0;
            b_idx_q  <= '0;
            b_acc_q  <= 1'b0;
        end else if (accept) begin
            opcode_q <= opcode_i;
            binary_q <= binary_i;
            a_idx_q  <= a_idx_i;
            a_acc_q  <= a_acc_i;
            b_idx_q  <= b_idx_i;
            b_acc_q  <= b_acc_i;
        end
    end

    // Captured instruction must not move unless a start is accepted
    assert_fields_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(opcode_q) && $stable(binary_q) && $stable(a_idx_q)
                     && $stable(a_acc_q) && $stable(b_idx_q) && $stable(b_acc_q)));

endmodule

// File: rtl/alu_seq_src_dec.sv
module alu_seq_src_dec
    import alu_seq_pkg::*;
#(
    parameter int NREG = 4,
    parameter int IDXW = 2
) (
    input  src_pick_e       pick,
    input  logic [IDXW-1:0] a_idx,
    input  logic            a_acc,
    input  logic [IDXW-1:0] b_idx,
    input  logic            b_acc,
    output logic [NREG-1:0] reg_en,
    output logic            acc_oe
);

    logic            drive;
    logic            sel_acc;
    logic [IDXW-1:0] sel_idx;

    always_comb begin
        drive   = 1'b0;
        sel_acc = 1'b0;
        sel_idx = '0;
        unique case (pick)
            PICK_A: begin
                drive   = 1'b1;
                sel_acc = a_acc;
                sel_idx = a_idx;
            end
            PICK_B: begin
                drive   = 1'b1;
                sel_acc = b_acc;
                sel_idx = b_idx;
            end
            default: begin
                drive   = 1'b0;
            end
        endcase
    end

    assign acc_oe = drive && sel_acc;

    for (genvar gi = 0; gi < NREG; gi++) begin : g_en
        assign reg_en[gi] = drive && !sel_acc && (sel_idx == IDXW'(gi));
    end

endmodule

// File: rtl/alu_seq_fsm.sv
module alu_seq_fsm
    import alu_seq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start,
    input  logic      binary_q,
    output logic      accept,
    output seq_ctrl_t ctrl
);

    seq_state_e st_q;
    seq_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    assign accept = (st_q == ST_IDLE) && start;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (start) st_d = ST_A_EN;
            ST_A_EN:  st_d = binary_q ? ST_A_TMP : ST_U_OP;
            ST_A_TMP: st_d = ST_B_EN;
            ST_B_EN:  st_d = ST_B_OP;
            ST_B_OP:  st_d = ST_B_ACC;
            ST_B_ACC: st_d = ST_DONE;
            ST_U_OP:  st_d = ST_U_ACC;
            ST_U_ACC: st_d = ST_DONE;
            ST_DONE:  st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctrl = '{pick: PICK_NONE, op_on: 1'b0, tmp_set: 1'b0,
                 acc_set: 1'b0, done: 1'b0, busy: 1'b1};
        unique case (st_q)
            ST_IDLE:  ctrl.busy = 1'b0;
            ST_A_EN:  ctrl.pick = PICK_A;
            ST_A_TMP: begin
                ctrl.pick    = PICK_A;
                ctrl.tmp_set = 1'b1;
            end
            ST_B_EN:  ctrl.pick = PICK_B;
            ST_B_OP:  begin
                ctrl.pick  = PICK_B;
                ctrl.op_on = 1'b1;
            end
            ST_B_ACC: begin
                ctrl.pick    = PICK_B;
                ctrl.op_on   = 1'b1;
                ctrl.acc_set = 1'b1;
            end
            ST_U_OP:  begin
                ctrl.pick  = PICK_A;
                ctrl.op_on = 1'b1;
            end
            ST_U_ACC: begin
                ctrl.pick    = PICK_A;
                ctrl.op_on   = 1'b1;
                ctrl.acc_set = 1'b1;
            end
            ST_DONE:  ctrl.done = 1'b1;
            default:  ctrl.busy = 1'b0;
        endcase
    end

    // TMP load is followed by the second operand alone on the bus
    assert_tmp_then_b_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.tmp_set |=> (ctrl.pick == PICK_B && !ctrl.op_on && !ctrl.tmp_set));

    assert_done_after_acc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.acc_set |=> (ctrl.done && ctrl.pick == PICK_NONE));

    // Accepted start produces the first step on the next cycle
    assert_first_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (ctrl.pick == PICK_A && !ctrl.op_on && !ctrl.tmp_set));

endmodule

// File: rtl/alu_step_seq.sv
module alu_step_seq
    import alu_seq_pkg::*;
#(
    parameter int             NREG     = 4,
    parameter int             OPW      = 4,
    parameter logic [OPW-1:0] NOP_CODE = '0,
    localparam int            IDXW     = (NREG > 1) ? $clog2(NREG) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [OPW-1:0]  instr_opcode,
    input  logic            instr_binary,
    input  logic [IDXW-1:0] instr_a_idx,
    input  logic            instr_a_acc,
    input  logic [IDXW-1:0] instr_b_idx,
    input  logic            instr_b_acc,
    output logic [NREG-1:0] reg_en,
    output logic            acc_oe,
    output logic            tmp_set,
    output logic            acc_set,
    output logic [OPW-1:0]  alu_op,
    output logic            busy,
    output logic            done
);

    logic            accept;
    seq_ctrl_t       ctrl;
    logic [OPW-1:0]  opcode_q;
    logic            binary_q;
    logic [IDXW-1:0] a_idx_q;
    logic            a_acc_q;
    logic [IDXW-1:0] b_idx_q;
    logic            b_acc_q;

    alu_seq_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .binary_q (binary_q),
        .accept   (accept),
        .ctrl     (ctrl)
    );

    alu_seq_latch #(.OPW(OPW), .IDXW(IDXW)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (accept),
        .opcode_i (instr_opcode),
        .binary_i (instr_binary),
        .a_idx_i  (instr_a_idx),
        .a_acc_i  (instr_a_acc),
        .b_idx_i  (instr_b_idx),
        .b_acc_i  (instr_b_acc),
        .opcode_q (opcode_q),
        .binary_q (binary_q),
        .a_idx_q  (a_idx_q),
        .a_acc_q  (a_acc_q),
        .b_idx_q  (b_idx_q),
        .b_acc_q  (b_acc_q)
    );

    alu_seq_src_dec #(.NREG(NREG), .IDXW(IDXW)) u_dec (
        .pick   (ctrl.pick),
        .a_idx  (a_idx_q),
        .a_acc  (a_acc_q),
        .b_idx  (b_idx_q),
        .b_acc  (b_acc_q),
        .reg_en (reg_en),
        .acc_oe (acc_oe)
    );

    assign alu_op  = ctrl.op_on ? opcode_q : NOP_CODE;
    assign tmp_set = ctrl.tmp_set;
    assign acc_set = ctrl.acc_set;
    assign busy    = ctrl.busy;
    assign done    = ctrl.done;

    assert_one_driver_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({reg_en, acc_oe}) <= 1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (reg_en == '0 && !acc_oe && alu_op == NOP_CODE && !tmp_set && !acc_set && !done));

    // Register loads always happen with a source on the bus (R2, R3)
    assert_load_has_driver_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_set || tmp_set) |-> ($countones({reg_en, acc_oe}) == 1));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    assert_done_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

endmodule

// File: tb/alu_step_seq_tb.sv
`timescale 1ns/1ps
module alu_step_seq_tb;

    localparam int NREG = 4;
    localparam int OPW  = 4;
    localparam logic [OPW-1:0] NOP = 4'd0;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [OPW-1:0]  instr_opcode = '0;
    logic            instr_binary = 1'b0;
    logic [1:0]      instr_a_idx = '0;
    logic            instr_a_acc = 1'b0;
    logic [1:0]      instr_b_idx = '0;
    logic            instr_b_acc = 1'b0;
    logic [NREG-1:0] reg_en;
    logic            acc_oe;
    logic            tmp_set;
    logic            acc_set;
    logic [OPW-1:0]  alu_op;
    logic            busy;
    logic            done;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    alu_step_seq #(.NREG(NREG), .OPW(OPW), .NOP_CODE(NOP)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .instr_opcode (instr_opcode),
        .instr_binary (instr_binary),
        .instr_a_idx  (instr_a_idx),
        .instr_a_acc  (instr_a_acc),
        .instr_b_idx  (instr_b_idx),
        .instr_b_acc  (instr_b_acc),
        .reg_en       (reg_en),
        .acc_oe       (acc_oe),
        .tmp_set      (tmp_set),
        .acc_set      (acc_set),
        .alu_op       (alu_op),
        .busy         (busy),
        .done         (done)
    );

    // Observed vector: {reg_en, acc_oe, tmp_set, acc_set, alu_op, busy, done}
    function automatic logic [12:0] observed();
        return {reg_en, acc_oe, tmp_set, acc_set, alu_op, busy, done};
    endfunction

    // Expected step output from the step table of R2 / R3 / R5
    function automatic logic [12:0] exp_step(input logic [3:0] op, input logic bin,
                                             input logic aacc, input logic [1:0] aidx,
                                             input logic bacc, input logic [1:0] bidx,
                                             input int s);
        logic use_b, op_on, tset, aset, sacc;
        logic [1:0] sidx;
        logic [3:0] en;
        use_b = bin && (s >= 2);
        op_on = bin ? (s >= 3) : (s >= 1);
        tset  = bin && (s == 1);
        aset  = bin ? (s == 4) : (s == 2);
        sacc  = use_b ? bacc : aacc;
        sidx  = use_b ? bidx : aidx;
        en    = sacc ? 4'b0000 : (4'b0001 << sidx);
        return {en, sacc, tset, aset, op_on ? op : NOP, 1'b1, 1'b0};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [12:0] act,
                       input logic [12:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Runs one instruction starting at a negedge while idle.
    task automatic run_instr(input logic [3:0] op, input logic bin,
                             input logic aacc, input logic [1:0] aidx,
                             input logic bacc, input logic [1:0] bidx,
                             input logic poke_busy, input logic poke_done);
        int nst;
        logic [12:0] e;
        logic [12:0] a;
        nst = bin ? 5 : 3;
        instr_opcode = op; instr_binary = bin;
        instr_a_acc = aacc; instr_a_idx = aidx;
        instr_b_acc = bacc; instr_b_idx = bidx;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int s = 0; s < nst; s++) begin
            e = exp_step(op, bin, aacc, aidx, bacc, bidx, s);
            a = observed();
            // R2 / R3 step table, R7 scrambled fields have no effect
            chk(a == e, bin ? "R3" : "R2", a, e);
            chk($countones({reg_en, acc_oe}) == 1, "R4", a, e);
            if (s == 0) chk(a == e, "R8 first step after start", a, e);
            if (s == 0 || s == 2) chk(a[12:8] == e[12:8], "R5 source decode", a, e);
            // R7: scramble fields and maybe poke start while busy
            instr_opcode = 4'($urandom);
            instr_binary = 1'($urandom);
            instr_a_idx  = 2'($urandom);
            instr_a_acc  = 1'($urandom);
            instr_b_idx  = 2'($urandom);
            instr_b_acc  = 1'($urandom);
            start = poke_busy && 1'($urandom);
            @(negedge clk);
            start = 1'b0;
        end
        e = {4'b0000, 1'b0, 1'b0, 1'b0, NOP, 1'b1, 1'b1};
        a = observed();
        chk(a == e, "R6 done pulse", a, e);
        chk(busy == 1'b1, "R9 busy in done cycle", a, e);
        start = poke_done;
        @(negedge clk);
        start = 1'b0;
        e = '0;
        a = observed();
        chk(a == e, poke_done ? "R7 start in done ignored" : "R6 idle after done", a, e);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin : stim
        logic [12:0] a;
        void'($urandom(32'h5EED_0A17));
        repeat (3) @(negedge clk);
        a = observed();
        chk(a == '0, "R1 reset state", a, '0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        a = observed();
        chk(a == '0, "R1 idle after reset", a, '0);

        // Directed corners
        run_instr(4'h5, 1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 1'b0, 1'b0); // R2 reg0
        run_instr(4'hA, 1'b1, 1'b0, 2'd3, 1'b0, 2'd1, 1'b0, 1'b0); // R3 reg3/reg1
        run_instr(4'h3, 1'b0, 1'b1, 2'd2, 1'b0, 2'd0, 1'b0, 1'b0); // R8 chain acc unary
        run_instr(4'h7, 1'b1, 1'b0, 2'd2, 1'b1, 2'd3, 1'b1, 1'b1); // R5 acc as B, R7 pokes
        run_instr(4'hF, 1'b1, 1'b1, 2'd1, 1'b1, 2'd2, 1'b1, 1'b1); // acc both operands
        run_instr(4'h1, 1'b0, 1'b0, 2'd3, 1'b1, 2'd0, 1'b1, 1'b1);

        // Random instructions, chained back-to-back
        for (int k = 0; k < 60; k++) begin
            run_instr(4'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                      1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom));
        end

        // Long idle gap: stays quiet (R1)
        repeat (4) @(negedge clk);
        a = observed();
        chk(a == '0, "R1 idle hold", a, '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule